// File: doc/BRIEF.md
# Table-Driven Shared Memory Slot Arbiter

The block lets up to sixteen requesting cores share a single synchronous memory port by time slicing. A programmable schedule of 64 entries sets the order of service. Each entry names the core that owns that slot. A slot pointer moves forward one entry on every clock and wraps at the end. By naming a core in more entries, that core gets a larger share of the port. It can hold every other slot, or several slots in a row.

When the owner of the current slot is not requesting, the slot is lent to another requester, so bandwidth is not left idle. An entry can also hold a value that names no core; such a slot always goes to whichever core is asking. A core that owns few slots can be clock-gated in the cycles between its grants.

The memory behind the port is a single-cycle synchronous RAM. A read that is granted in one cycle returns its word in the next cycle, on that core's own read-data lane.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, rvalid_o is zero and every read-data lane is zero. Schedule entry k holds k mod 16. The first cycle after reset is served from entry 0.
- R2: gnt_o has at most one bit set. It has exactly one bit set in any cycle where req_i is nonzero, and it is zero when req_i is zero. The grant is combinational in the same cycle as the request.
- R3: When the current entry holds a value below 16 and that core's req_i bit is set, the grant goes to that core.
- R4: When the current entry names a core whose req_i bit is clear, the slot goes to the lowest-index core that is requesting.
- R5: When the current entry holds a value of 16 or more (5-bit field), the slot goes to the lowest-index core that is requesting.
- R6: The slot pointer moves forward one entry on each clock and wraps from entry 63 to entry 0.
- R7: tbl_we_i writes tbl_owner_i into entry tbl_idx_i at the clock edge. A slot decided in the same cycle as the write still uses the old value. The new value applies from the pointer's next visit to that entry.
- R8: When the granted core has we_i set, its wdata lane is stored at its address lane at the clock edge. Requests that are not granted leave the memory unchanged.
- R9: When the granted core has we_i clear, its rvalid_o bit is set in the following cycle, and its rdata_o lane carries the word stored at its address. A lane holds its last value otherwise. rvalid_o is zero in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Schedule entry write strobe |
| tbl_idx_i | input | 6 | Schedule entry to write |
| tbl_owner_i | input | 5 | Core number to store; 16 and above means unowned |
| req_i | input | 16 | Per-core access request |
| we_i | input | 16 | Per-core write enable |
| addr_i | input | 128 | Per-core word address, 8 bits per lane, core c at bits c*8 |
| wdata_i | input | 512 | Per-core write data, 32 bits per lane, core c at bits c*32 |
| gnt_o | output | 16 | One-hot grant for the current slot |
| rvalid_o | output | 16 | Per-core read return strobe |
| rdata_o | output | 512 | Per-core read data lanes, 32 bits each |

## Verification
The grant is combinational, so the bench settles new inputs just after a falling edge and compares gnt_o with a schedule model in that same cycle. Schedule writes and memory writes enter the model only after that comparison, which matches the state the RTL holds at the next rising edge. A granted read is checked one full cycle later, at the following falling edge, on rvalid_o and on the granted core's lane. The expected word comes from a memory model that takes only granted writes.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  typedef enum logic [1:0] {
    GK_NONE  = 2'd0,
    GK_OWNER = 2'd1,
    GK_LENT  = 2'd2
  } grant_kind_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int N_SLOTS = 64,
  parameter int N_CORES = 16,
  parameter int CID_W   = 5,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [CID_W-1:0] wval_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic [CID_W-1:0] owner_o
);
  logic [CID_W-1:0] tbl_q [N_SLOTS];
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_q == IDX_W'(N_SLOTS-1)) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  // reset image is plain round-robin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOTS; i++) tbl_q[i] <= CID_W'(i % N_CORES);
    end else if (we_i) begin
      tbl_q[widx_i] <= wval_i;
    end
  end

  assign ptr_o   = ptr_q;
  assign owner_o = tbl_q[ptr_q];
endmodule

// File: rtl/slot_pick.sv
module slot_pick
  import slot_arb_pkg::*;
#(
  parameter int N_CORES = 16,
  parameter int CID_W   = 5,
  localparam int GID_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic [CID_W-1:0]   owner_i,
  input  logic [N_CORES-1:0] req_i,
  output logic [N_CORES-1:0] gnt_o,
  output logic [GID_W-1:0]   gidx_o,
  output logic               gvalid_o,
  output grant_kind_e        kind_o
);
  logic             owned;
  logic [GID_W-1:0] oidx;
  logic [GID_W-1:0] low_idx;

  assign owned = (owner_i < CID_W'(N_CORES));
  assign oidx  = owner_i[GID_W-1:0];

  always_comb begin
    low_idx = '0;
    for (int i = N_CORES-1; i >= 0; i--) begin
      if (req_i[i]) low_idx = GID_W'(i);
    end
  end

  always_comb begin
    gidx_o   = '0;
    gvalid_o = 1'b0;
    kind_o   = GK_NONE;
    if (owned && req_i[oidx]) begin
      gidx_o   = oidx;
      gvalid_o = 1'b1;
      kind_o   = GK_OWNER;
    end else if (|req_i) begin
      gidx_o   = low_idx;
      gvalid_o = 1'b1;
      kind_o   = GK_LENT;
    end
    gnt_o = '0;
    if (gvalid_o) gnt_o[gidx_o] = 1'b1;
  end
endmodule

// File: rtl/shared_ram.sv
module shared_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q       <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int N_CORES = 16,
  parameter int N_SLOTS = 64,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(N_SLOTS),
  localparam int CID_W  = $clog2(N_CORES) + 1,
  localparam int GID_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tbl_we_i,
  input  logic [IDX_W-1:0]            tbl_idx_i,
  input  logic [CID_W-1:0]            tbl_owner_i,
  input  logic [N_CORES-1:0]          req_i,
  input  logic [N_CORES-1:0]          we_i,
  input  logic [N_CORES*ADDR_W-1:0]   addr_i,
  input  logic [N_CORES*DATA_W-1:0]   wdata_i,
  output logic [N_CORES-1:0]          gnt_o,
  output logic [N_CORES-1:0]          rvalid_o,
  output logic [N_CORES*DATA_W-1:0]   rdata_o
);
  logic [IDX_W-1:0]  slot_ptr;
  logic [CID_W-1:0]  slot_owner;
  logic [GID_W-1:0]  gidx;
  logic              gvalid;
  grant_kind_e       gkind;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;
  logic [N_CORES-1:0] rd_pend_q;

  slot_table #(
    .N_SLOTS(N_SLOTS), .N_CORES(N_CORES), .CID_W(CID_W)
  ) i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .widx_i  (tbl_idx_i),
    .wval_i  (tbl_owner_i),
    .ptr_o   (slot_ptr),
    .owner_o (slot_owner)
  );

  slot_pick #(
    .N_CORES(N_CORES), .CID_W(CID_W)
  ) i_pick (
    .owner_i  (slot_owner),
    .req_i    (req_i),
    .gnt_o    (gnt_o),
    .gidx_o   (gidx),
    .gvalid_o (gvalid),
    .kind_o   (gkind)
  );

  assign ram_addr  = addr_i[gidx*ADDR_W +: ADDR_W];
  assign ram_wdata = wdata_i[gidx*DATA_W +: DATA_W];
  assign ram_we    = we_i[gidx];

  shared_ram #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_ram (
    .clk_i   (clk_i),
    .en_i    (gvalid),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= '0;
    else         rd_pend_q <= gnt_o & ~we_i;
  end

  assign rvalid_o = rd_pend_q;

  // each lane shows fresh data in the return cycle, then holds it
  for (genvar c = 0; c < N_CORES; c++) begin : g_lane
    logic [DATA_W-1:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           hold_q <= '0;
      else if (rd_pend_q[c]) hold_q <= ram_rdata;
    end
    assign rdata_o[c*DATA_W +: DATA_W] = rd_pend_q[c] ? ram_rdata : hold_q;
  end

  logic unused_kind;
  assign unused_kind = ^gkind;
endmodule

// File: rtl/slot_arbiter_chk.sv
module slot_arbiter_chk #(
  parameter int N_CORES = 16,
  parameter int N_SLOTS = 64,
  parameter int CID_W   = 5,
  localparam int IDX_W  = $clog2(N_SLOTS),
  localparam int GID_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CORES-1:0] req_i,
  input logic [N_CORES-1:0] we_i,
  input logic [N_CORES-1:0] gnt_i,
  input logic [N_CORES-1:0] rvalid_i,
  input logic [CID_W-1:0]   owner_i,
  input logic [IDX_W-1:0]   ptr_i
);
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_GNT_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i)); // R2
  AST_GNT_WHEN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> $countones(gnt_i) == 1); // R2
  AST_GNT_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i & ~req_i) == '0); // R2
  AST_OWNER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_i < CID_W'(N_CORES) && req_i[owner_i[GID_W-1:0]])
      |-> gnt_i[owner_i[GID_W-1:0]]); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (($past(ptr_i) == IDX_W'(N_SLOTS-1)) ? (ptr_i == '0)
                                                      : (ptr_i == $past(ptr_i) + 1'b1))); // R6
  AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> rvalid_i == $past(gnt_i & ~we_i)); // R9
endmodule

bind slot_arbiter slot_arbiter_chk #(
  .N_CORES(N_CORES), .N_SLOTS(N_SLOTS), .CID_W(CID_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .gnt_i    (gnt_o),
  .rvalid_i (rvalid_o),
  .owner_i  (slot_owner),
  .ptr_i    (slot_ptr)
);

// File: tb/test_slot_arbiter.sv
module test_slot_arbiter;
  localparam int N  = 16;
  localparam int S  = 64;
  localparam int AW = 8;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tbl_we = 1'b0;
  logic [5:0]      tbl_idx = '0;
  logic [4:0]      tbl_owner = '0;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0]    gnt;
  logic [N-1:0]    rvalid;
  logic [N*DW-1:0] rdata;

  slot_arbiter i_slot_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx),
    .tbl_owner_i(tbl_owner), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [4:0]    tbl_m [S];
  int            ptr_m;
  logic [DW-1:0] mem_m [1 << AW];
  logic [AW-1:0] b_addr [N];
  logic [DW-1:0] b_wdata [N];
  logic [N-1:0]  exp_rv = '0;
  int            exp_core = -1;
  logic [DW-1:0] exp_rdata = '0;
  string         extra = "";

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int model_pick(logic [N-1:0] r, output string tag);
    logic [4:0] o;
    o = tbl_m[ptr_m];
    if (r == '0) begin
      tag = "R2";
      return -1;
    end
    if (o < 5'(N) && r[o[3:0]]) begin
      tag = "R3 R6 R2";
      return int'(o);
    end
    tag = (o < 5'(N)) ? "R4 R2" : "R5 R2";
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return -1;
  endfunction

  task automatic step();
    string tag;
    int g;
    logic [N-1:0] expg;
    check("R9 rvalid", DW'(rvalid), DW'(exp_rv));
    if (exp_core >= 0) check("R9 R8 lane", rdata[exp_core*DW +: DW], exp_rdata);
    for (int c = 0; c < N; c++) begin
      addr[c*AW +: AW]  = b_addr[c];
      wdata[c*DW +: DW] = b_wdata[c];
    end
    #1;
    g = model_pick(req, tag);
    expg = (g >= 0) ? (N'(1) << g) : '0;
    check({tag, extra}, DW'(gnt), DW'(expg));
    exp_rv = '0;
    exp_core = -1;
    if (g >= 0) begin
      if (we[g]) mem_m[b_addr[g]] = b_wdata[g];
      else begin
        exp_rv = N'(1) << g;
        exp_core = g;
        exp_rdata = mem_m[b_addr[g]];
      end
    end
    if (tbl_we) tbl_m[tbl_idx] = tbl_owner;
    ptr_m = (ptr_m + 1) % S;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240406));
    for (int k = 0; k < S; k++) tbl_m[k] = 5'(k % N);
    ptr_m = 0;
    for (int c = 0; c < N; c++) begin b_addr[c] = '0; b_wdata[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at the ports
    check("R1 rvalid", DW'(rvalid), '0);
    check("R1 lanes", DW'(rdata != '0), '0);
    req = '1;
    #1;
    check("R1 entry0", DW'(gnt), 32'h1);
    step();

    // fill memory, one core at a time (borrowed slots)
    req = '0; we = '0;
    for (int a = 0; a < (1 << AW); a++) begin
      int c;
      c = a % N;
      req = N'(1) << c; we = N'(1) << c;
      b_addr[c] = AW'(a); b_wdata[c] = 32'hA5000000 ^ (a * 32'h9E37);
      step();
    end

    // R4: single reader across all owners
    req = N'(1) << 9; we = '0;
    for (int k = 0; k < 20; k++) begin b_addr[9] = AW'(k * 7); step(); end

    // R2: idle cycles
    req = '0;
    repeat (4) step();

    // R5: mark entries unowned, two readers
    tbl_we = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tbl_idx = 6'((ptr_m + 10 + k) % S); tbl_owner = 5'(16 + k);
      step();
    end
    tbl_we = 1'b0;
    req = (N'(1) << 3) | (N'(1) << 7); we = '0;
    for (int k = 0; k < 70; k++) begin
      b_addr[3] = AW'(k); b_addr[7] = AW'(k + 100); step();
    end

    // R7: rewrite the entry in use; old value now, new one pass later
    extra = " R7";
    req = (N'(1) << 2) | (N'(1) << 12);
    tbl_we = 1'b1; tbl_idx = 6'(ptr_m); tbl_owner = 5'd12;
    step();
    tbl_we = 1'b0;
    repeat (S) step();
    tbl_we = 1'b1; tbl_idx = 6'(ptr_m); tbl_owner = 5'd2;
    step();
    tbl_we = 1'b0;
    repeat (S) step();
    extra = "";

    // R3 R8 R9: heavy random traffic with schedule rewrites
    for (int k = 0; k < 3000; k++) begin
      req = N'($urandom);
      if ($urandom % 2) req = req & N'($urandom);
      we = N'($urandom);
      for (int c = 0; c < N; c++) begin
        b_addr[c] = AW'($urandom); b_wdata[c] = $urandom;
      end
      tbl_we = ($urandom % 16) == 0;
      tbl_idx = 6'($urandom); tbl_owner = 5'($urandom);
      step();
    end
    tbl_we = 1'b0; req = '0;
    step();
    step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule